// File: doc/BRIEF.md
# Colour Subcarrier Phase Accumulator

This block produces the colour-subcarrier phase for every pixel clock of an analogue video encoder. A coarse 12-bit phase register advances by a programmable increment on each clock. Two modulo accumulators sit beside it and trim the frequency. Each one adds its own 15-bit increment and wraps at a programmable size. On the clock where the mid accumulator wraps, the coarse phase takes one extra LSB. On the clock where the fine accumulator wraps, the mid accumulator takes one extra LSB. This cascade lets the average phase step be a rational number with a large denominator, which is how a subcarrier that is not an integer fraction of the pixel clock is hit exactly.

The phase word feeds a sine lookup elsewhere. A field-start pulse comes from the vertical timer and advances a small field counter. A two-bit cadence code chooses how often the three accumulators are forced back to zero at a field start, or disables that clearing. Each clearing is signalled by a one-cycle indication that is aligned with the zeroed phase.

Top module: `scphase_dda`

## Requirements
- R1: While `rst_n` is low at a clock edge, `phase` becomes 0, `cadence_reset` becomes 0, both fraction accumulators become 0 and the field counter becomes 0. The first field start after reset therefore always clears, for every cadence code except 3.
- R2: With `coarse_en` high and no carry arriving, `phase` advances by `coarse_inc` on each clock, modulo 4096.
- R3: With `coarse_en` low, `phase` holds its value on every clock that does not clear, and any carry arriving on that clock is dropped.
- R4: With `mid_en` high, the mid accumulator computes acc + `mid_inc` + carry-in. When that sum is at least `mid_size`, it stores sum − `mid_size` and the coarse phase gains one extra LSB on the same clock. Otherwise it stores the sum. This assumes `mid_inc` < `mid_size`.
- R5: With `fine_en` high, the fine accumulator behaves the same way against `fine_size`, and its carry is added to the mid accumulator's sum on the same clock.
- R6: A fraction accumulator whose enable is low keeps its value and produces no carry. A carry arriving at a disabled mid accumulator is dropped. When the accumulator is enabled again it resumes from the value it held.
- R7: Each clock with `field_start` high advances the 3-bit field counter. On that clock all three accumulators clear if the counter's low bits are zero. Code 0 checks 1 low bit (every 2nd field), code 1 checks 2 bits (every 4th field) and code 2 checks 3 bits (every 8th field).
- R8: With cadence code 3 the accumulators are never cleared and `cadence_reset` stays low, while the field counter keeps counting.
- R9: A clearing takes priority over every increment and carry. After that clock edge, `phase` is 0 and `cadence_reset` is high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| field_start | input | 1 | One-cycle pulse at the start of each field |
| period_code | input | 2 | Clearing cadence: 0 = every 2 fields, 1 = every 4 fields, 2 = every 8 fields, 3 = never |
| coarse_en | input | 1 | Enables the coarse phase register |
| coarse_inc | input | PHASE_W (12) | Coarse phase increment per clock |
| mid_en | input | 1 | Enables the mid fraction accumulator |
| mid_inc | input | FRAC_W (15) | Mid accumulator increment |
| mid_size | input | FRAC_W (15) | Mid accumulator rollover size |
| fine_en | input | 1 | Enables the fine fraction accumulator |
| fine_inc | input | FRAC_W (15) | Fine accumulator increment |
| fine_size | input | FRAC_W (15) | Fine accumulator rollover size |
| phase | output | PHASE_W (12) | Subcarrier phase word |
| cadence_reset | output | 1 | High for one cycle, together with the zeroed phase, after a cadence clearing |

## Verification
The bench builds the block with its default parameters: a 12-bit phase, 15-bit fraction accumulators and a 3-bit field counter. Those defaults put the 4096 wrap of the coarse phase and the full 8-field cadence within a few hundred cycles.

The bench drives small rollover sizes (7 and 5). With these, carries from both fraction accumulators arrive every few clocks and sometimes coincide. That exercises the cascaded carry, the behaviour of a disabled accumulator between two enabled ones, and clearing in the middle of an accumulation. Every cadence code is run through several fields, and the code is changed while the field counter is mid-count.

// File: rtl/scphase_pkg.sv
// Package: shared types and helpers for the subcarrier phase accumulator.
// Assumes the field counter is at least three bits wide so that an
// eight-field cadence can be expressed.
package scphase_pkg;

    // Cadence code carried on the period_code port.
    typedef enum logic [1:0] {
        CAD_EVERY_2 = 2'd0,
        CAD_EVERY_4 = 2'd1,
        CAD_EVERY_8 = 2'd2,
        CAD_OFF     = 2'd3
    } cadence_e;

    // Number of low counter bits that must be zero for a clearing.
    function automatic int unsigned cadence_bits(input cadence_e code);
        case (code)
            CAD_EVERY_2: return 1;
            CAD_EVERY_4: return 2;
            CAD_EVERY_8: return 3;
            default:     return 0;
        endcase
    endfunction

endpackage

// File: rtl/scphase_modacc.sv
// Module: modulo fraction accumulator.
// Adds an increment plus a carry-in every enabled clock. When the sum
// reaches the rollover size it subtracts the size once and raises a
// combinational carry for the same clock. Assumes inc < size, so a single
// subtraction keeps the stored value below size. When disabled it holds
// and raises no carry. A synchronous clear wins over everything.
module scphase_modacc #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] inc,
    input  logic [W-1:0] size,
    input  logic         cin,
    output logic         cout
);

    logic [W-1:0] acc_q;
    logic [W:0]   sum;
    logic         over;
    logic [W-1:0] next_acc;

    // Sum, rollover test and wrapped value for this clock.
    always_comb begin
        sum      = {1'b0, acc_q} + {1'b0, inc} + {{W{1'b0}}, cin};
        over     = (sum >= {1'b0, size});
        next_acc = over ? W'(sum - {1'b0, size}) : sum[W-1:0];
        cout     = en & over;
    end

    // Accumulator register: reset/clear, advance when enabled, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= next_acc;
        end
    end

endmodule

// File: rtl/scphase_coarse.sv
// Module: coarse phase register.
// Advances by inc plus one carry LSB each enabled clock and wraps modulo
// 2**W. Holds when disabled (an arriving carry is then lost). A synchronous
// clear wins over the increment.
module scphase_coarse #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] inc,
    input  logic         cin,
    output logic [W-1:0] phase
);

    logic [W-1:0] phase_q;

    // Phase register: clear, advance with carry, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase_q <= '0;
        end else if (en) begin
            phase_q <= phase_q + inc + {{(W-1){1'b0}}, cin};
        end
    end

    assign phase = phase_q;

endmodule

// File: rtl/scphase_cadence.sv
// Module: field counter and cadence clearing decision.
// Counts field-start pulses in a CNT_W-bit wrapping counter. On a field
// start it asks for a clearing when the counter's low bits, chosen by
// the cadence code, are all zero. The decision is combinational for the
// accumulators; the indication output is its registered copy. Assumes
// CNT_W >= 3.
module scphase_cadence
    import scphase_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       field_start,
    input  logic [1:0] period_code,
    output logic       clear,
    output logic       cadence_reset
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;
    int unsigned      nbits;

    // Build the low-bit mask from the cadence code; code 3 gives no clearing.
    always_comb begin
        nbits = cadence_bits(cadence_e'(period_code));
        mask  = '0;
        for (int i = 0; i < CNT_W; i++) begin
            if (i < int'(nbits)) mask[i] = 1'b1;
        end
        clear = field_start && (nbits != 0) && ((cnt_q & mask) == '0);
    end

    // Field counter: advances on every field start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (field_start) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Registered clearing indication, aligned with the zeroed phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cadence_reset <= 1'b0;
        end else begin
            cadence_reset <= clear;
        end
    end

endmodule

// File: rtl/scphase_dda.sv
// Module: colour subcarrier phase accumulator (top).
// Cascades NUM_FRAC modulo accumulators, finest first, into a coarse
// phase register. Every carry moves through the chain within the same
// clock. A cadence unit clears all stages on selected field starts.
// Assumes each increment is below its rollover size.
module scphase_dda #(
    parameter int PHASE_W   = 12,
    parameter int FRAC_W    = 15,
    parameter int CADENCE_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               field_start,
    input  logic [1:0]         period_code,
    input  logic               coarse_en,
    input  logic [PHASE_W-1:0] coarse_inc,
    input  logic               mid_en,
    input  logic [FRAC_W-1:0]  mid_inc,
    input  logic [FRAC_W-1:0]  mid_size,
    input  logic               fine_en,
    input  logic [FRAC_W-1:0]  fine_inc,
    input  logic [FRAC_W-1:0]  fine_size,
    output logic [PHASE_W-1:0] phase,
    output logic               cadence_reset
);

    localparam int NUM_FRAC = 2;

    logic              clr;
    logic              frac_en   [NUM_FRAC];
    logic [FRAC_W-1:0] frac_inc  [NUM_FRAC];
    logic [FRAC_W-1:0] frac_size [NUM_FRAC];
    logic [NUM_FRAC:0] carry;

    // Stage 0 is the fine accumulator, stage 1 the mid one.
    assign frac_en[0]   = fine_en;
    assign frac_inc[0]  = fine_inc;
    assign frac_size[0] = fine_size;
    assign frac_en[1]   = mid_en;
    assign frac_inc[1]  = mid_inc;
    assign frac_size[1] = mid_size;
    assign carry[0]     = 1'b0;

    scphase_cadence #(
        .CNT_W(CADENCE_W)
    ) u_cadence (
        .clk          (clk),
        .rst_n        (rst_n),
        .field_start  (field_start),
        .period_code  (period_code),
        .clear        (clr),
        .cadence_reset(cadence_reset)
    );

    for (genvar g = 0; g < NUM_FRAC; g++) begin : g_frac
        scphase_modacc #(
            .W(FRAC_W)
        ) u_acc (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (clr),
            .en   (frac_en[g]),
            .inc  (frac_inc[g]),
            .size (frac_size[g]),
            .cin  (carry[g]),
            .cout (carry[g+1])
        );
    end

    scphase_coarse #(
        .W(PHASE_W)
    ) u_coarse (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .en   (coarse_en),
        .inc  (coarse_inc),
        .cin  (carry[NUM_FRAC]),
        .phase(phase)
    );

endmodule

// File: rtl/scphase_dda_chk.sv
// Module: port-level property checker for scphase_dda, bound below.
// Assumes field_start and period_code are the only clearing sources.
module scphase_dda_chk #(
    parameter int PHASE_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               field_start,
    input logic [1:0]         period_code,
    input logic               coarse_en,
    input logic               mid_en,
    input logic [PHASE_W-1:0] coarse_inc,
    input logic [PHASE_W-1:0] phase,
    input logic               cadence_reset
);

    logic               past_ok;
    logic [PHASE_W-1:0] prev_phase;
    logic [PHASE_W-1:0] prev_inc;
    logic [PHASE_W-1:0] step_err;

    // Marks that the previous cycle was out of reset, and keeps last values.
    always_ff @(posedge clk) begin
        past_ok    <= rst_n;
        prev_phase <= phase;
        prev_inc   <= coarse_inc;
    end

    assign step_err = phase - prev_phase - prev_inc;

    // R2: an enabled step is the increment plus at most one carry LSB.
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(coarse_en) && !cadence_reset) |-> (step_err <= 1));

    // R3: a disabled coarse register holds.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(coarse_en) && !cadence_reset) |-> (phase == prev_phase));

    // R6: with the mid accumulator off, no extra LSB reaches the phase.
    p_no_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(coarse_en) && !$past(mid_en) && !cadence_reset) |-> (step_err == 0));

    // R7: an indication is always caused by a field start.
    p_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cadence_reset |-> (past_ok && $past(field_start)));

    // R8: cadence code 3 never produces a clearing.
    p_never_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && ($past(period_code) == 2'd3)) |-> !cadence_reset);

    // R9: the indication comes with a zero phase and lasts one cycle.
    p_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cadence_reset |-> (phase == '0));

    p_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cadence_reset |=> !cadence_reset);

endmodule

bind scphase_dda scphase_dda_chk #(
    .PHASE_W(PHASE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .field_start  (field_start),
    .period_code  (period_code),
    .coarse_en    (coarse_en),
    .mid_en       (mid_en),
    .coarse_inc   (coarse_inc),
    .phase        (phase),
    .cadence_reset(cadence_reset)
);

// File: tb/sim_scphase_dda.sv
`timescale 1ns/1ps
// Bench: scoreboard for scphase_dda. The driver task computes the expected
// phase and indication from the requirements and queues them. The monitor
// pops one item after each rising edge and compares it with the outputs.
module sim_scphase_dda;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        field_start = 1'b0;
    logic [1:0]  period_code = 2'd0;
    logic        coarse_en = 1'b0;
    logic [11:0] coarse_inc = '0;
    logic        mid_en = 1'b0;
    logic [14:0] mid_inc = '0;
    logic [14:0] mid_size = 15'd1;
    logic        fine_en = 1'b0;
    logic [14:0] fine_inc = '0;
    logic [14:0] fine_size = 15'd1;
    logic [11:0] phase;
    logic        cadence_reset;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state, built from the requirements.
    int m_phase = 0;
    int m_mid = 0;
    int m_fine = 0;
    int m_cnt = 0;

    int    q_phase[$];
    bit    q_cad[$];
    string q_tag[$];

    always #2 clk = ~clk;

    scphase_dda u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .field_start  (field_start),
        .period_code  (period_code),
        .coarse_en    (coarse_en),
        .coarse_inc   (coarse_inc),
        .mid_en       (mid_en),
        .mid_inc      (mid_inc),
        .mid_size     (mid_size),
        .fine_en      (fine_en),
        .fine_inc     (fine_inc),
        .fine_size    (fine_size),
        .phase        (phase),
        .cadence_reset(cadence_reset)
    );

    // Driver: called at a falling edge, predicts the next rising edge.
    task automatic cyc(input bit fs, input string tag);
        int  s;
        bit  c_fine;
        bit  c_mid;
        bit  clr;
        int  mask;
        field_start = fs;
        mask = (period_code == 2'd0) ? 1 : (period_code == 2'd1) ? 3 : 7;
        clr  = fs && (period_code != 2'd3) && ((m_cnt & mask) == 0);
        if (fs) m_cnt = (m_cnt + 1) % 8;
        if (clr) begin
            m_phase = 0;
            m_mid   = 0;
            m_fine  = 0;
        end else begin
            c_fine = 0;
            if (fine_en) begin
                s = m_fine + int'(fine_inc);
                if (s >= int'(fine_size)) begin
                    s -= int'(fine_size);
                    c_fine = 1;
                end
                m_fine = s;
            end
            c_mid = 0;
            if (mid_en) begin
                s = m_mid + int'(mid_inc) + int'(c_fine);
                if (s >= int'(mid_size)) begin
                    s -= int'(mid_size);
                    c_mid = 1;
                end
                m_mid = s;
            end
            if (coarse_en) m_phase = (m_phase + int'(coarse_inc) + int'(c_mid)) % 4096;
        end
        q_phase.push_back(m_phase);
        q_cad.push_back(clr);
        q_tag.push_back(tag);
        @(negedge clk);
        field_start = 1'b0;
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, tag);
    endtask

    task automatic fields(input int nf, input int len, input string tag);
        for (int f = 0; f < nf; f++) begin
            cyc(1'b1, tag);
            run(len - 1, tag);
        end
    endtask

    // Monitor: compare outputs one step after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_phase.size() != 0) begin
                int    ep;
                bit    ec;
                string t;
                ep = q_phase.pop_front();
                ec = q_cad.pop_front();
                t  = q_tag.pop_front();
                checks++;
                if (int'(phase) != ep || cadence_reset != ec) begin
                    errors++;
                    $display("FAIL %s: phase=%0d cad=%0b expected phase=%0d cad=%0b",
                             t, phase, cadence_reset, ep, ec);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with nonzero inputs applied during reset.
        coarse_en  = 1'b1;
        coarse_inc = 12'd99;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (phase != 12'd0 || cadence_reset != 1'b0) begin
            errors++;
            $display("FAIL R1: phase=%0d cad=%0b expected phase=0 cad=0", phase, cadence_reset);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2: coarse stepping through the 4096 wrap.
        coarse_inc = 12'd1000;
        run(20, "R2 coarse wrap");

        // R3: coarse disabled holds.
        coarse_en = 1'b0;
        run(8, "R3 hold");
        coarse_en  = 1'b1;
        coarse_inc = 12'd16;

        // R4: mid accumulator carries into the phase.
        mid_en   = 1'b1;
        mid_inc  = 15'd3;
        mid_size = 15'd7;
        run(30, "R4 mid carry");

        // R5: fine accumulator carries into the mid one.
        fine_en   = 1'b1;
        fine_inc  = 15'd2;
        fine_size = 15'd5;
        run(40, "R5 fine cascade");

        // R6: disabled mid holds and drops the fine carry; then resume.
        mid_en = 1'b0;
        run(20, "R6 mid disabled");
        mid_en  = 1'b1;
        fine_en = 1'b0;
        run(20, "R6 fine disabled");
        fine_en = 1'b1;
        run(10, "R6 resume");

        // R3: carry arriving at a disabled coarse register is lost.
        coarse_en = 1'b0;
        run(10, "R3 carry dropped");
        coarse_en  = 1'b1;
        coarse_inc = 12'd37;

        // R7: the cadence codes; the first pulse clears from the R1 count of zero.
        period_code = 2'd0;
        fields(6, 5, "R7 every 2");
        period_code = 2'd1;
        fields(9, 4, "R7 every 4");
        period_code = 2'd2;
        fields(17, 3, "R7 every 8");

        // R8: never clearing, counter keeps running underneath.
        period_code = 2'd3;
        fields(10, 3, "R8 never");

        // R9: clearing wins over increments; back-to-back field pulses.
        period_code = 2'd0;
        coarse_inc  = 12'd4095;
        fields(6, 1, "R9 clear priority");
        run(6, "R9 after clear");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule